// File: doc/BRIEF.md
# Dual-Channel Serial DAC Command Front End

This block is the digital side of a two-channel, 12-bit digital-to-analog converter. A host sends 16-bit command words over a three-wire serial link: an active-low select, a serial clock and a data line. The block samples the three wires in its own system clock domain and assembles each frame. The top four bits of a frame are control bits and the low twelve are a sample. It keeps a holding buffer and one 12-bit output latch per channel. Because of the buffer, one command can move new values into both channels in the same clock cycle. It also drives a power-down flag and a fast-settling flag to the analog section.

Two framing modes are available, chosen per frame. In plain mode, the frame is committed when the select line rises, and the last sixteen bits shifted in are used. In counted mode, the block counts clocks from the select falling edge. It commits as soon as the sixteenth bit has arrived, then ignores the serial clock until the select line goes high again. In both modes, a frame shorter than sixteen bits is dropped.

Top module: `dual_dac_serial_if`

## Requirements
- R1: After synchronous reset, both channel outputs, the holding buffer, the power-down flag, the fast flag and the update strobe are all 0, which means slow mode.
- R2: Frames are sent MSB first, and each data bit is taken at a falling edge of the serial clock. Bit 15 is select-high, bit 14 is fast, bit 13 is power-down, bit 12 is select-low, and bits 11:0 are the sample.
- R3: When select-high is 1, a committed frame loads the sample into channel A. In the same cycle it loads the previous buffer contents into channel B. The buffer is left unchanged.
- R4: When select-high and select-low are both 0, a committed frame loads the sample into channel B and into the buffer. Channel A is left unchanged.
- R5: When select-high is 0 and select-low is 1, a committed frame loads only the buffer. Both channel outputs stay unchanged and no update strobe is raised.
- R6: Every committed frame copies its fast and power-down bits to the two flag outputs.
- R7: In plain mode, the commit happens at the rising edge of the select line, but only if at least sixteen falling clock edges were seen. With more than sixteen, the last sixteen bits form the frame.
- R8: A frame that ends with fewer than sixteen falling clock edges changes no output, in either mode.
- R9: In counted mode, the frame commits after the sixteenth falling clock edge without waiting for the select line to rise. Later clock edges in that frame change nothing. The mode input is sampled at the select falling edge.
- R10: The update strobe is high for exactly one cycle per committed write to a channel. Any change of a channel output occurs only in a cycle where the strobe is high.
- R11: Serial clock edges while the select line is high change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csn_i | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data |
| auto_term_i | input | 1 | 1 = counted mode, 0 = plain mode |
| chan_a_o | output | 12 | Channel A latch |
| chan_b_o | output | 12 | Channel B latch |
| power_down_o | output | 1 | Power-down flag |
| fast_mode_o | output | 1 | Fast-settling flag |
| update_o | output | 1 | One-cycle strobe on a channel write |

## Verification
A fault in the shift register or the bit counter shows up at a frame boundary. The wrong sample, or the wrong target channel, appears a few system cycles after the commit point. A lost or extra count shows as a dropped frame or an early commit. In counted mode, an early commit is visible while the select line is still low. A buffer fault stays hidden until the next select-high write copies the buffer into channel B. The bench therefore follows every buffer-only write with such a write.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;
  localparam int DATA_W  = 12;
  localparam int CTRL_W  = 4;
  localparam int FRAME_W = DATA_W + CTRL_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic              sel_hi;
    logic              fast;
    logic              pdn;
    logic              sel_lo;
    logic [DATA_W-1:0] data;
  } cmd_word_t;
endpackage

// File: rtl/dac_sync_edge.sv
module dac_sync_edge #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_o <= RST_VAL;
    else     prev_o <= chain[STAGES-1];
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx
  import dac_if_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             sck_fall,
  input  logic             sdi,
  input  logic             auto_term,
  output logic             commit_o,
  output logic [FRAME_W-1:0] word_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic in_frame, locked, auto_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_o <= 1'b0;
      word_o   <= '0;
      cnt_o    <= '0;
      in_frame <= 1'b0;
      locked   <= 1'b0;
      auto_q   <= 1'b0;
    end else begin
      commit_o <= 1'b0;
      if (cs_fall) begin
        cnt_o    <= '0;
        locked   <= 1'b0;
        in_frame <= 1'b1;
        auto_q   <= auto_term;
      end else if (in_frame && cs_rise) begin
        in_frame <= 1'b0;
        if (!auto_q && cnt_o == FULL) commit_o <= 1'b1;
      end else if (in_frame && sck_fall && !locked) begin
        word_o <= {word_o[FRAME_W-2:0], sdi};
        if (cnt_o != FULL) cnt_o <= cnt_o + 1'b1;
        if (auto_q && cnt_o == FULL - 1'b1) begin
          locked   <= 1'b1;
          commit_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dac_latch_bank.sv
module dac_latch_bank
  import dac_if_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  cmd_word_t         cmd,
  output logic [DATA_W-1:0] chan_a_o,
  output logic [DATA_W-1:0] chan_b_o,
  output logic              power_down_o,
  output logic              fast_mode_o,
  output logic              update_o
);
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_a_o     <= '0;
      chan_b_o     <= '0;
      hold_q       <= '0;
      power_down_o <= 1'b0;
      fast_mode_o  <= 1'b0;
      update_o     <= 1'b0;
    end else begin
      update_o <= 1'b0;
      if (commit) begin
        power_down_o <= cmd.pdn;
        fast_mode_o  <= cmd.fast;
        if (cmd.sel_hi) begin
          chan_a_o <= cmd.data;
          chan_b_o <= hold_q;
          update_o <= 1'b1;
        end else if (!cmd.sel_lo) begin
          chan_b_o <= cmd.data;
          hold_q   <= cmd.data;
          update_o <= 1'b1;
        end else begin
          hold_q <= cmd.data;
        end
      end
    end
  end
endmodule

// File: rtl/dual_dac_serial_if.sv
module dual_dac_serial_if
  import dac_if_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csn_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              auto_term_i,
  output logic [DATA_W-1:0] chan_a_o,
  output logic [DATA_W-1:0] chan_b_o,
  output logic              power_down_o,
  output logic              fast_mode_o,
  output logic              update_o
);
  logic [2:0]         pins_s, pins_p;
  logic               cs_fall_w, cs_rise_w, sck_fall_w;
  logic               commit_w;
  logic [FRAME_W-1:0] word_w;
  logic [CNT_W-1:0]   frame_cnt_w;

  dac_sync_edge #(
    .WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)
  ) sync_i (
    .clk(clk), .rst(rst),
    .async_i({sdi_i, sclk_i, csn_i}),
    .sync_o(pins_s), .prev_o(pins_p)
  );

  assign cs_fall_w  =  pins_p[0] & ~pins_s[0];
  assign cs_rise_w  = ~pins_p[0] &  pins_s[0];
  assign sck_fall_w =  pins_p[1] & ~pins_s[1] & ~pins_s[0];

  dac_frame_rx rx_i (
    .clk(clk), .rst(rst),
    .cs_fall(cs_fall_w), .cs_rise(cs_rise_w), .sck_fall(sck_fall_w),
    .sdi(pins_s[2]), .auto_term(auto_term_i),
    .commit_o(commit_w), .word_o(word_w), .cnt_o(frame_cnt_w)
  );

  dac_latch_bank bank_i (
    .clk(clk), .rst(rst),
    .commit(commit_w), .cmd(cmd_word_t'(word_w)),
    .chan_a_o(chan_a_o), .chan_b_o(chan_b_o),
    .power_down_o(power_down_o), .fast_mode_o(fast_mode_o),
    .update_o(update_o)
  );
endmodule

// File: rtl/dual_dac_serial_if_chk.sv
module dual_dac_serial_if_chk
  import dac_if_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              commit,
  input logic [CNT_W-1:0]  frame_cnt,
  input logic [DATA_W-1:0] chan_a,
  input logic [DATA_W-1:0] chan_b,
  input logic              pdn,
  input logic              fast,
  input logic              upd
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (chan_a == '0 && chan_b == '0 && !pdn && !fast && !upd));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    upd |=> !upd);

  a_r10_a_moves_with_strobe: assert property (@(posedge clk) disable iff (rst)
    !$stable(chan_a) |-> upd);

  a_r10_b_moves_with_strobe: assert property (@(posedge clk) disable iff (rst)
    !$stable(chan_b) |-> upd);

  a_r8_commit_full_frame: assert property (@(posedge clk) disable iff (rst)
    commit |-> frame_cnt == CNT_W'(FRAME_W));

  a_r9_count_bounded: assert property (@(posedge clk) disable iff (rst)
    frame_cnt <= CNT_W'(FRAME_W));
endmodule

bind dual_dac_serial_if dual_dac_serial_if_chk chk_i (
  .clk(clk), .rst(rst), .commit(commit_w), .frame_cnt(frame_cnt_w),
  .chan_a(chan_a_o), .chan_b(chan_b_o), .pdn(power_down_o),
  .fast(fast_mode_o), .upd(update_o)
);

// File: tb/dual_dac_serial_if_tb_top.sv
module dual_dac_serial_if_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csn = 1'b1, sclk = 1'b1, sdi = 1'b0, auto_m = 1'b0;
  logic [11:0] chan_a, chan_b;
  logic pdn, fast, upd;

  int checks = 0;
  int fails  = 0;
  int upd_cnt = 0;
  int bad_change = 0;
  logic [11:0] last_a = '0, last_b = '0;

  always #5 clk = ~clk;

  dual_dac_serial_if dut_i (
    .clk(clk), .rst(rst), .csn_i(csn), .sclk_i(sclk), .sdi_i(sdi),
    .auto_term_i(auto_m), .chan_a_o(chan_a), .chan_b_o(chan_b),
    .power_down_o(pdn), .fast_mode_o(fast), .update_o(upd)
  );

  always @(negedge clk) begin
    if (upd) upd_cnt++;
    if (!rst && !upd && (chan_a != last_a || chan_b != last_b)) bad_change++;
    last_a = chan_a;
    last_b = chan_b;
  end

  typedef struct packed {
    logic [15:0] word;
    logic [11:0] a;
    logic [11:0] b;
    logic        pd;
    logic        fs;
    logic        up;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{16'h45A5, 12'h000, 12'h5A5, 1'b0, 1'b1, 1'b1},
    '{16'h33C3, 12'h000, 12'h5A5, 1'b1, 1'b0, 1'b0},
    '{16'hCABC, 12'hABC, 12'h3C3, 1'b0, 1'b1, 1'b1},
    '{16'h9001, 12'h001, 12'h3C3, 1'b0, 1'b0, 1'b1},
    '{16'h6FFF, 12'h001, 12'hFFF, 1'b1, 1'b1, 1'b1},
    '{16'h8800, 12'h800, 12'hFFF, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      wait_clk(4);
      sclk = 1'b0;
      wait_clk(4);
      sclk = 1'b1;
    end
  endtask

  task automatic frame(input logic [31:0] bits, input int n);
    upd_cnt = 0;
    csn = 1'b0;
    wait_clk(4);
    shift_bits(bits, n);
    wait_clk(4);
    csn = 1'b1;
    wait_clk(12);
  endtask

  task automatic chk_state(input string req, input logic [11:0] a, input logic [11:0] b,
                           input logic p, input logic f);
    chk({req, " chan A"}, chan_a, a);
    chk({req, " chan B"}, chan_b, b);
    chk({req, " power-down"}, pdn, p);
    chk({req, " fast"}, fast, f);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    chk_state("R1 reset", 12'h000, 12'h000, 1'b0, 1'b0);
    chk("R1 strobe idle", upd, 0);

    // R2 R3 R4 R5 R6 R7: plain-mode vectors
    for (int v = 0; v < 6; v++) begin
      frame({16'h0, VEC[v].word}, 16);
      chk_state("R2-field plain vector", VEC[v].a, VEC[v].b, VEC[v].pd, VEC[v].fs);
      chk("R10 strobe count", upd_cnt, int'(VEC[v].up));
    end

    // R8: short plain frame dropped
    frame({16'h0, 16'h4123}, 10);
    chk_state("R8 short plain", 12'h800, 12'hFFF, 1'b0, 1'b0);
    chk("R8 no strobe", upd_cnt, 0);

    // R7: 18 clocks, last 16 kept (code 00, sample 111)
    frame({14'h0, 2'b11, 16'h0111}, 18);
    chk_state("R7 long plain", 12'h800, 12'h111, 1'b0, 1'b0);

    // R11: clocks while select high
    upd_cnt = 0;
    shift_bits(32'h0000_FFFF, 16);
    wait_clk(12);
    chk_state("R11 idle clocks", 12'h800, 12'h111, 1'b0, 1'b0);
    chk("R11 no strobe", upd_cnt, 0);

    // R9: counted mode commits before select rises
    auto_m = 1'b1;
    upd_cnt = 0;
    csn = 1'b0;
    wait_clk(4);
    shift_bits({16'h0, 16'hC222}, 16);
    wait_clk(20);
    chk_state("R9 early commit", 12'h222, 12'h111, 1'b0, 1'b1);
    shift_bits(32'h0000_000F, 4);
    wait_clk(4);
    csn = 1'b1;
    wait_clk(12);
    chk_state("R9 extra bits ignored", 12'h222, 12'h111, 1'b0, 1'b1);
    chk("R9 single strobe", upd_cnt, 1);

    // R8: short counted frame dropped
    frame({24'h0, 8'h0F}, 8);
    chk_state("R8 short counted", 12'h222, 12'h111, 1'b0, 1'b1);
    chk("R10 no stray change", bad_change, 0);

    // R1: reset from a non-zero state
    auto_m = 1'b0;
    rst = 1'b1;
    wait_clk(3);
    rst = 1'b0;
    wait_clk(2);
    chk_state("R1 reset again", 12'h000, 12'h000, 1'b0, 1'b0);
    // R3: buffer is zero after reset, so select-high write moves 0 into B
    frame({16'h0, 16'h8555}, 16);
    chk_state("R3 buffer cleared", 12'h555, 12'h000, 1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule